// File: doc/BRIEF.md
# Low-Word Leading-Zero Count Execute Unit

This unit executes one instruction of a 64-bit RISC integer pipeline: the count-leading-zeros operation on the low 32-bit word of a source register, in both its plain form and its record form. Each cycle it can accept an instruction word, the 64-bit source operand and the current summary-overflow bit. One clock later it returns the destination register index, a zero-extended 64-bit count with a register write enable, and, for the record form, a 4-bit condition field with its own enable.

Instruction bits use big-endian numbering, so bit 0 is the MSB of the word (port bit 31). Any word whose opcodes do not match raises an illegal flag instead of writing anything. The count comes from a log-depth tree of halving zero tests, so the combinational depth grows with log2 of the word width.

Top module: `clz_word_exu`

## Requirements
- R1: A word is legal only when bits 0-5 (instr[31:26]) equal 31 and bits 21-30 (instr[10:1]) equal 26. The plain-form word with every register field zero is 0x7C000034.
- R2: A word that fails R1 sets `illegal` and asserts neither `gpr_we` nor `cr_we`. A legal word clears `illegal` and asserts `gpr_we`.
- R3: The count is the number of zero bits above the highest set bit of src_val[31:0]. src_val[63:32] has no effect on any output.
- R4: When src_val[31:0] is zero, the result is 32, whatever the upper half holds.
- R5: When src_val[31] is set, the result is 0.
- R6: The result is zero-extended, so result[63:6] is always zero.
- R7: `dst_idx` carries bits 11-15 of the word (instr[20:16]).
- R8: `cr_we` is asserted only for a legal word whose record flag, bit 31 (instr[0]), is 1.
- R9: `cr_field` is {LT, GT, EQ, SO} from bit 3 down to bit 0. LT is always 0. EQ is 1 and GT is 0 when the count is 0; otherwise GT is 1 and EQ is 0. SO equals the `so_in` captured with the word.
- R10: Outputs appear, and `out_valid` is high, exactly one clock after `in_valid` is sampled high. With `out_valid` low, both write enables and `illegal` are low.
- R11: Synchronous active-high `rst` clears `out_valid`, `gpr_we`, `cr_we` and `illegal` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the inputs |
| instr | input | 32 | Instruction word |
| src_val | input | 64 | Source register value |
| so_in | input | 1 | Current summary-overflow bit |
| out_valid | output | 1 | Result valid, one cycle after capture |
| dst_idx | output | 5 | Destination register index |
| result | output | 64 | Zero-extended count |
| gpr_we | output | 1 | Register write enable |
| cr_field | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr_we | output | 1 | Condition field write enable |
| illegal | output | 1 | Unrecognised instruction |

## Verification
The bench walks a single set bit through every position of the low word. A tree stage that picks the wrong half, or fails to shift, then shows up as a count that is off by a power of two. It places ones only in the upper half with a zero low word: a unit that counts across all 64 bits would return 0 there instead of 32. It tries words that are wrong in only one bit of the primary or the extended opcode, which catches a decoder that checks just one field or writes on an illegal op. It also toggles the record flag and `so_in` against counts of zero and nonzero. A swapped EQ/GT pair, a stale SO bit or a condition write on the plain form then shows up as a field mismatch.

// File: rtl/clzw_pkg.sv
package clzw_pkg;
    localparam int unsigned XLEN      = 64;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned CNT_W     = $clog2(WORD_W) + 1;
    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned CR_W      = 4;
    localparam logic [5:0]  OPC_MAIN  = 6'd31;
    localparam logic [9:0]  OPC_EXT   = 10'd26;

    typedef struct packed {
        logic                  valid;
        logic [REG_IDX_W-1:0]  dst;
        logic [XLEN-1:0]       res;
        logic                  gpr_we;
        logic [CR_W-1:0]       cr;
        logic                  cr_we;
        logic                  illegal;
    } exu_state_t;
endpackage

// File: rtl/clzw_decode.sv
module clzw_decode
    import clzw_pkg::*;
(
    input  logic [31:0]          instr,
    output logic                 legal,
    output logic                 record_form,
    output logic [REG_IDX_W-1:0] dst_idx
);
    // Big-endian field numbering: bit 0 of the word is port bit 31.
    logic [5:0] main_op;
    logic [9:0] ext_op;

    always_comb begin
        main_op     = instr[31:26];
        ext_op      = instr[10:1];
        legal       = (main_op == OPC_MAIN) && (ext_op == OPC_EXT);
        record_form = instr[0];
        dst_idx     = instr[20:16];
    end
endmodule

// File: rtl/clzw_lzc.sv
module clzw_lzc #(
    parameter int unsigned W = 32,
    localparam int unsigned LVL = $clog2(W)
) (
    input  logic [W-1:0] word,
    output logic [LVL:0] count
);
    // Halving tree: stage i tests the top 2**i bits and shifts them out when they are zero.
    logic [W-1:0]   stg [0:LVL];
    logic [LVL-1:0] bits;

    assign stg[LVL] = word;

    for (genvar i = LVL - 1; i >= 0; i--) begin : g_stage
        localparam int unsigned HALF = 2 ** i;
        logic top_zero;
        assign top_zero = (stg[i+1][W-1 -: HALF] == '0);
        assign bits[i]  = top_zero;
        assign stg[i]   = top_zero ? (stg[i+1] << HALF) : stg[i+1];
    end

    always_comb begin
        if (word == '0) count = (LVL+1)'(W);
        else            count = {1'b0, bits};
    end
endmodule

// File: rtl/clzw_crgen.sv
module clzw_crgen
    import clzw_pkg::*;
(
    input  logic [CNT_W-1:0] count,
    input  logic             so,
    output logic [CR_W-1:0]  cr
);
    logic is_zero;

    always_comb begin
        // Signed compare of a nonnegative count against zero: never less-than.
        is_zero = (count == '0);
        cr      = {1'b0, !is_zero, is_zero, so};
    end
endmodule

// File: rtl/clz_word_exu.sv
module clz_word_exu
    import clzw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic [63:0] src_val,
    input  logic        so_in,
    output logic        out_valid,
    output logic [4:0]  dst_idx,
    output logic [63:0] result,
    output logic        gpr_we,
    output logic [3:0]  cr_field,
    output logic        cr_we,
    output logic        illegal
);
    logic                 dec_legal;
    logic                 dec_rec;
    logic [REG_IDX_W-1:0] dec_dst;
    logic [CNT_W-1:0]     cnt;
    logic [CR_W-1:0]      cr_calc;
    exu_state_t           st_d, st_q;

    clzw_decode u_dec (
        .instr       (instr),
        .legal       (dec_legal),
        .record_form (dec_rec),
        .dst_idx     (dec_dst)
    );

    clzw_lzc #(.W(WORD_W)) u_lzc (
        .word  (src_val[WORD_W-1:0]),
        .count (cnt)
    );

    clzw_crgen u_cr (
        .count (cnt),
        .so    (so_in),
        .cr    (cr_calc)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valid   = in_valid;
        st_d.gpr_we  = 1'b0;
        st_d.cr_we   = 1'b0;
        st_d.illegal = 1'b0;
        if (in_valid) begin
            st_d.dst     = dec_dst;
            st_d.res     = {{(XLEN-CNT_W){1'b0}}, cnt};
            st_d.cr      = cr_calc;
            st_d.gpr_we  = dec_legal;
            st_d.cr_we   = dec_legal && dec_rec;
            st_d.illegal = !dec_legal;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign dst_idx   = st_q.dst;
    assign result    = st_q.res;
    assign gpr_we    = st_q.gpr_we;
    assign cr_field  = st_q.cr;
    assign cr_we     = st_q.cr_we;
    assign illegal   = st_q.illegal;

    assert_no_write_on_illegal_R2: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!gpr_we && !cr_we));
    assert_upper_result_zero_R6: assert property (@(posedge clk) disable iff (rst)
        gpr_we |-> (result[63:6] == '0 && result[5:0] <= 6'd32));
    assert_cr_only_with_write_R8: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> gpr_we);
    assert_cr_never_lt_R9: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> (!cr_field[3] && (cr_field[2] != cr_field[1])));
    assert_eq_iff_zero_R9: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> (cr_field[1] == (result == '0)));
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_follows_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !gpr_we && !cr_we && !illegal));
    assert_so_copied_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && $past(!rst)) |=> (cr_field[0] == $past(so_in)));
endmodule

// File: tb/clz_word_exu_bench.sv
module clz_word_exu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src_val = '0;
    logic        so_in = 1'b0;
    logic        out_valid, gpr_we, cr_we, illegal;
    logic [4:0]  dst_idx;
    logic [63:0] result;
    logic [3:0]  cr_field;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // expected values for the next compare
    bit          e_valid = 0;
    bit          e_legal, e_rec;
    logic [4:0]  e_dst;
    logic [63:0] e_res;
    logic [3:0]  e_cr;

    always #10 clk = ~clk;

    clz_word_exu u_clz_word_exu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_val(src_val), .so_in(so_in), .out_valid(out_valid),
        .dst_idx(dst_idx), .result(result), .gpr_we(gpr_we),
        .cr_field(cr_field), .cr_we(cr_we), .illegal(illegal)
    );

    function automatic logic [31:0] mk(input logic [5:0] po, input logic [4:0] rs,
                                       input logic [4:0] ra, input logic [4:0] rb,
                                       input logic [9:0] xo, input logic rc);
        return {po, rs, ra, rb, xo, rc};
    endfunction

    function automatic int ref_count(input logic [63:0] v);
        for (int k = 31; k >= 0; k--) if (v[k]) return 31 - k;
        return 32;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        if (!e_valid) begin
            chk("R10 out_valid idle", 64'(out_valid), 64'd0);
            chk("R10 enables idle", {61'd0, gpr_we, cr_we, illegal}, 64'd0);
        end else begin
            chk("R10 out_valid", 64'(out_valid), 64'd1);
            chk("R2 illegal", 64'(illegal), 64'(!e_legal));
            chk("R2 gpr_we", 64'(gpr_we), 64'(e_legal));
            chk("R8 cr_we", 64'(cr_we), 64'(e_legal && e_rec));
            if (e_legal) begin
                chk("R7 dst_idx", 64'(dst_idx), 64'(e_dst));
                chk("R3 R4 R5 R6 result", result, e_res);
                if (e_rec) chk("R9 cr_field", 64'(cr_field), 64'(e_cr));
            end
        end
    endtask

    // compare previous cycle's expectation, then drive this cycle's inputs
    task automatic step(input bit v, input logic [31:0] w, input logic [63:0] s, input bit so);
        int n;
        @(negedge clk);
        compare();
        in_valid = v; instr = w; src_val = s; so_in = so;
        n = ref_count(s);
        e_valid = v;
        e_legal = (w[31:26] == 6'd31) && (w[10:1] == 10'd26);
        e_rec   = w[0];
        e_dst   = w[20:16];
        e_res   = 64'(n);
        e_cr    = {1'b0, n != 0, n == 0, so};
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs cleared during reset
        chk("R11 reset out_valid", 64'(out_valid), 64'd0);
        chk("R11 reset enables", {61'd0, gpr_we, cr_we, illegal}, 64'd0);
        rst = 1'b0;
        e_valid = 0;
        // R1: base word with zero register fields
        step(1, 32'h7C00_0034, 64'h0000_0000_0000_0001, 0);
        step(1, 32'h7C00_0035, 64'h0, 1);
        // R4: zero low word, upper half ones
        step(1, mk(6'd31, 5'd3, 5'd7, 5'd0, 10'd26, 1'b1), 64'hFFFF_FFFF_0000_0000, 0);
        // R5: top bit of low word set
        step(1, mk(6'd31, 5'd4, 5'd9, 5'd0, 10'd26, 1'b1), 64'h0000_0000_8000_0000, 1);
        step(1, mk(6'd31, 5'd4, 5'd31, 5'd17, 10'd26, 1'b1), 64'h7FFF_FFFF_FFFF_FFFF, 0);
        // R3: walking one through the low word, with upper-half noise
        for (int k = 0; k < 32; k++)
            step(1, mk(6'd31, 5'(k), 5'(31 - k), 5'd0, 10'd26, 1'(k % 2)),
                 {32'hA5A5_0000 | 32'(k), 32'd1 << k}, 1'(k % 3 == 0));
        // R2: single-bit opcode faults in either field
        step(1, mk(6'd30, 5'd1, 5'd2, 5'd0, 10'd26, 1'b1), 64'h10, 0);
        step(1, mk(6'd63, 5'd1, 5'd2, 5'd0, 10'd26, 1'b0), 64'h10, 0);
        step(1, mk(6'd31, 5'd1, 5'd2, 5'd0, 10'd27, 1'b1), 64'h10, 1);
        step(1, mk(6'd31, 5'd1, 5'd2, 5'd0, 10'd58, 1'b0), 64'h10, 0);
        // R10: gaps between instructions
        step(0, mk(6'd31, 5'd1, 5'd2, 5'd0, 10'd26, 1'b1), 64'h10, 0);
        step(1, mk(6'd31, 5'd1, 5'd5, 5'd0, 10'd26, 1'b1), 64'h0000_0000_0000_0100, 1);
        step(0, 32'h0, 64'h0, 0);
        step(0, 32'h0, 64'h0, 0);
        // random mixture
        for (int k = 0; k < 300; k++) begin
            logic [31:0] w;
            logic [63:0] s;
            w = mk(($urandom % 4 == 0) ? 6'($urandom) : 6'd31, 5'($urandom), 5'($urandom),
                   5'($urandom), ($urandom % 5 == 0) ? 10'($urandom) : 10'd26, 1'($urandom));
            s = {32'($urandom), 32'($urandom) >> ($urandom % 33)};
            step(1'($urandom % 4 != 0), w, s, 1'($urandom));
        end
        // R11: reset in the middle of a stream
        step(1, mk(6'd31, 5'd1, 5'd2, 5'd0, 10'd26, 1'b1), 64'h1, 1);
        @(negedge clk);
        compare();
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        chk("R11 mid-run reset valid", 64'(out_valid), 64'd0);
        chk("R11 mid-run reset enables", {61'd0, gpr_we, cr_we, illegal}, 64'd0);
        rst = 1'b0; in_valid = 1'b0;
        e_valid = 0;
        step(0, 32'h0, 64'h0, 0);
        @(negedge clk);
        compare();
        finish_run();
    end
endmodule